// File: doc/BRIEF.md
# Overriding Branch Direction Predictor

This block gives a fetch unit two opinions on each conditional branch. A small bimodal table of two-bit counters answers in the same cycle as the lookup, and fetch follows that answer at once. A global-history table answers for the same branch a fixed number of cycles later. Its index is the branch address XORed with a shift register of recent outcomes. That second answer is the more accurate one. When it differs from the first, the block raises an override. The override carries the branch's tag and the corrected direction, so the front end can take a short redirect of a couple of cycles instead of waiting for a full misprediction at execute.

A shift pipeline as deep as the slow predictor's latency carries each lookup's tag and both directions, so every comparison lines up with its own branch. A flush clears every pending slot, so squashed branches never raise an override. Both tables learn only from resolved outcomes. The history register shifts at resolve time. A counter records how many overrides have been raised.

Top module: `ovr_bpred`

## Requirements
- R1: `fast_dir_o` shows, in the same cycle as a lookup, bit 1 of the bimodal counter indexed by `lookup_pc_i[FAST_IDX_W+1:2]`; 1 means taken.
- R2: A lookup accepted in cycle n whose slow direction differs from its fast direction drives `override_valid_o` high for exactly one cycle, in cycle n+SLOW_LAT. In that cycle `override_tag_o` equals the lookup's tag and `override_dir_o` equals the slow direction.
- R3: `override_valid_o` stays low when the two directions of a lookup agree, and in any cycle with no lookup SLOW_LAT cycles earlier.
- R4: `flush_i` high in cycle f drops every lookup accepted in cycles f-SLOW_LAT+1 through f, including a lookup presented in cycle f itself; none of them raises an override.
- R5: An update with `update_valid_i` moves the bimodal counter at `update_pc_i[FAST_IDX_W+1:2]` and the global counter at `update_pc_i[HIST_W+1:2]` XOR history, one step toward the outcome, saturating at 0 and 3. After that, the history shifts left and takes the outcome into bit 0.
- R6: `disagree_cnt_o` rises by one in the cycle after each cycle with `override_valid_o` high, and holds otherwise.
- R7: Lookups on consecutive cycles are compared independently, and their overrides come out in lookup order on consecutive cycles.
- R8: After reset, every counter is 1 (weakly not taken), the history is zero, no slot is pending, and `disagree_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | A branch is looked up this cycle |
| lookup_pc_i | input | PC_W | Address of the branch being looked up |
| lookup_tag_i | input | TAG_W | Tag the front end assigns to the branch |
| fast_dir_o | output | 1 | Same-cycle bimodal direction |
| flush_i | input | 1 | Drop all pending comparisons |
| override_valid_o | output | 1 | Slow prediction disagrees with the fast one |
| override_tag_o | output | TAG_W | Tag of the branch being overridden |
| override_dir_o | output | 1 | Corrected (slow) direction |
| update_valid_i | input | 1 | A resolved outcome is presented |
| update_pc_i | input | PC_W | Address of the resolved branch |
| update_taken_i | input | 1 | Resolved direction |
| disagree_cnt_o | output | CNT_W | Number of overrides raised |

## Verification
The assertions take for granted that `lookup_valid_i` and `flush_i` are known in every cycle after reset, that SLOW_LAT is at least 2, and that the override count never wraps within a run. The stimulus drives every input from reset onward, always to 0 or 1. It raises only a few dozen overrides against a 16-bit counter. It never applies updates while a batch of lookups is in flight. Because of that, the expected directions, which are fixed at lookup time from the bench's own table model, cannot shift under a pending comparison.

// File: rtl/ovr_bpred_pkg.sv
package ovr_bpred_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_RESET = 2'd1;

  function automatic ctr2_t ctr_step(ctr2_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/ovr_bpred_table.sv
module ovr_bpred_table
  import ovr_bpred_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_dir_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  ctr2_t ctr_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_step(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_dir_o = ctr_dir(ctr_q[rd_idx_i]);

endmodule

// File: rtl/ovr_bpred_pipe.sv
module ovr_bpred_pipe #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic         vld_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic         vld_d;
    logic [W-1:0] dat_d;
    if (g == 0) begin : g_head
      assign vld_d = in_valid_i;
      assign dat_d = in_data_i;
    end else begin : g_body
      assign vld_d = vld_q[g-1];
      assign dat_d = dat_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        dat_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_d & ~flush_i;
        dat_q[g] <= dat_d;
      end
    end
  end

  assign out_valid_o = vld_q[DEPTH-1];
  assign out_data_o  = dat_q[DEPTH-1];

endmodule

// File: rtl/ovr_bpred.sv
module ovr_bpred
  import ovr_bpred_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned TAG_W      = 6,
  parameter int unsigned FAST_IDX_W = 8,
  parameter int unsigned HIST_W     = 8,
  parameter int unsigned SLOW_LAT   = 3,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [PC_W-1:0]  lookup_pc_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  output logic             fast_dir_o,
  input  logic             flush_i,
  output logic             override_valid_o,
  output logic [TAG_W-1:0] override_tag_o,
  output logic             override_dir_o,
  input  logic             update_valid_i,
  input  logic [PC_W-1:0]  update_pc_i,
  input  logic             update_taken_i,
  output logic [CNT_W-1:0] disagree_cnt_o
);
  localparam int unsigned PAY_W = TAG_W + 2;

  logic [HIST_W-1:0] ghr_q;
  logic              slow_dir;
  logic              out_vld;
  logic [PAY_W-1:0]  out_pay;
  logic              out_fast, out_slow;
  logic [TAG_W-1:0]  out_tag;
  logic [CNT_W-1:0]  cnt_q;

  ovr_bpred_table #(.IDX_W(FAST_IDX_W)) u_fast (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lookup_pc_i[FAST_IDX_W+1:2]),
    .rd_dir_o   (fast_dir_o),
    .wr_en_i    (update_valid_i),
    .wr_idx_i   (update_pc_i[FAST_IDX_W+1:2]),
    .wr_taken_i (update_taken_i)
  );

  // slow array is read at lookup; its answer is held back SLOW_LAT cycles
  ovr_bpred_table #(.IDX_W(HIST_W)) u_slow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lookup_pc_i[HIST_W+1:2] ^ ghr_q),
    .rd_dir_o   (slow_dir),
    .wr_en_i    (update_valid_i),
    .wr_idx_i   (update_pc_i[HIST_W+1:2] ^ ghr_q),
    .wr_taken_i (update_taken_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ghr_q <= '0;
    else if (update_valid_i) ghr_q <= {ghr_q[HIST_W-2:0], update_taken_i};
  end

  ovr_bpred_pipe #(.DEPTH(SLOW_LAT), .W(PAY_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .in_valid_i  (lookup_valid_i),
    .in_data_i   ({lookup_tag_i, fast_dir_o, slow_dir}),
    .out_valid_o (out_vld),
    .out_data_o  (out_pay)
  );

  assign {out_tag, out_fast, out_slow} = out_pay;

  assign override_valid_o = out_vld & (out_fast ^ out_slow);
  assign override_tag_o   = out_tag;
  assign override_dir_o   = out_slow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (override_valid_o) cnt_q <= cnt_q + 1'b1;
  end

  assign disagree_cnt_o = cnt_q;

endmodule

// File: rtl/ovr_bpred_chk.sv
module ovr_bpred_chk #(
  parameter int unsigned SLOW_LAT = 3,
  parameter int unsigned CNT_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic             flush_i,
  input logic             override_valid_o,
  input logic [CNT_W-1:0] disagree_cnt_o
);
  // shadow of accepted lookups, independent of the design's pipe
  logic [SLOW_LAT-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= {pend_q[SLOW_LAT-2:0], lookup_valid_i};
  end

  AST_OVR_HAS_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_valid_o |-> pend_q[SLOW_LAT-1]);  // R3

  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !override_valid_o);  // R4

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_valid_o |=> disagree_cnt_o == $past(disagree_cnt_o) + 1'b1);  // R6

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !override_valid_o |=> $stable(disagree_cnt_o));  // R6

  AST_OVR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(override_valid_o));  // R8

endmodule

bind ovr_bpred ovr_bpred_chk #(.SLOW_LAT(SLOW_LAT), .CNT_W(CNT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .lookup_valid_i   (lookup_valid_i),
  .flush_i          (flush_i),
  .override_valid_o (override_valid_o),
  .disagree_cnt_o   (disagree_cnt_o)
);

// File: tb/ovr_bpred_bench.sv
module ovr_bpred_bench;
  localparam int PC_W = 32, TAG_W = 6, FIW = 8, HW = 8, LAT = 3, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lv = 0, fl = 0, uv = 0, ut = 0;
  logic [PC_W-1:0]  lpc = '0, upc = '0;
  logic [TAG_W-1:0] ltag = '0;
  logic fdir, ovld, odir;
  logic [TAG_W-1:0] otag;
  logic [CW-1:0] cnt;

  always #2.5 clk = ~clk;

  ovr_bpred #(.PC_W(PC_W), .TAG_W(TAG_W), .FAST_IDX_W(FIW), .HIST_W(HW),
              .SLOW_LAT(LAT), .CNT_W(CW)) u_ovr_bpred (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lv), .lookup_pc_i(lpc),
    .lookup_tag_i(ltag), .fast_dir_o(fdir), .flush_i(fl),
    .override_valid_o(ovld), .override_tag_o(otag), .override_dir_o(odir),
    .update_valid_i(uv), .update_pc_i(upc), .update_taken_i(ut),
    .disagree_cnt_o(cnt));

  int checks = 0, errors = 0;
  int exp_cnt = 0;

  // reference tables
  logic [1:0]    fm [1<<FIW];
  logic [1:0]    sm [1<<HW];
  logic [HW-1:0] ghr_m;

  // batch descriptors
  logic [PC_W-1:0]  b_pc  [8];
  logic [TAG_W-1:0] b_tag [8];
  logic             b_ovr [8];
  logic             b_dir [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<FIW); i++) fm[i] = 2'd1;
    for (int i = 0; i < (1<<HW); i++)  sm[i] = 2'd1;
    ghr_m = '0;
  endtask

  task automatic do_update(input logic [PC_W-1:0] pc, input logic t);
    logic [HW-1:0] si;
    uv = 1; upc = pc; ut = t;
    fm[pc[FIW+1:2]] = sat(fm[pc[FIW+1:2]], t);
    si = pc[HW+1:2] ^ ghr_m;
    sm[si] = sat(sm[si], t);
    ghr_m = {ghr_m[HW-2:0], t};
    @(negedge clk);
    uv = 0;
  endtask

  // runs n lookups on consecutive cycles from a negedge; flush_at<0 means none
  task automatic run_batch(input int n, input int flush_at, input string req);
    int cyc_end;
    cyc_end = n + LAT;
    for (int i = 0; i < n; i++) begin
      logic f, s;
      f = fm[b_pc[i][FIW+1:2]][1];
      s = sm[b_pc[i][HW+1:2] ^ ghr_m][1];
      b_dir[i] = s;
      b_ovr[i] = (f != s) && !(flush_at >= 0 && i <= flush_at && i + LAT > flush_at);
    end
    for (int cyc = 0; cyc < cyc_end; cyc++) begin
      int k;
      k = cyc - LAT;
      if (k >= 0) begin
        chk(ovld == b_ovr[k], req, "override_valid", ovld, b_ovr[k]);
        if (b_ovr[k]) begin
          chk(otag == b_tag[k], "R2", "override_tag", otag, b_tag[k]);
          chk(odir == b_dir[k], "R2", "override_dir", odir, b_dir[k]);
          exp_cnt++;
        end
      end else begin
        chk(ovld == 1'b0, "R3", "override before latency", ovld, 0);
      end
      fl = (cyc == flush_at);
      if (cyc < n) begin
        lv = 1; lpc = b_pc[cyc]; ltag = b_tag[cyc];
        #1;
        chk(fdir == fm[b_pc[cyc][FIW+1:2]][1], "R1", "fast_dir",
            fdir, fm[b_pc[cyc][FIW+1:2]][1]);
      end else begin
        lv = 0;
      end
      @(negedge clk);
    end
    lv = 0; fl = 0;
    chk(cnt == CW'(exp_cnt), "R6", "disagree_cnt", cnt, exp_cnt);
  endtask

  task automatic test_reset();
    chk(ovld == 1'b0, "R8", "override after reset", ovld, 0);
    chk(cnt == '0, "R8", "count after reset", cnt, 0);
    lpc = 32'h0000_0abc; #1;
    chk(fdir == 1'b0, "R8", "fast dir after reset", fdir, 0);
  endtask

  task automatic test_agree();
    b_pc[0] = 32'h100; b_tag[0] = 6'd1;
    run_batch(1, -1, "R3");
  endtask

  task automatic test_train_disagree();
    do_update(32'h40, 1'b1);
    do_update(32'h40, 1'b1);
    chk(ghr_m == 8'h03, "R5", "history model", ghr_m, 3);
    b_pc[0] = 32'h40; b_tag[0] = 6'd9;
    run_batch(1, -1, "R2");
    chk(exp_cnt == 1, "R5", "trained lookup disagrees", exp_cnt, 1);
  endtask

  task automatic test_back_to_back();
    b_pc[0] = 32'h40;  b_tag[0] = 6'd5;
    b_pc[1] = 32'h100; b_tag[1] = 6'd6;
    b_pc[2] = 32'h40;  b_tag[2] = 6'd7;
    b_pc[3] = 32'h44;  b_tag[3] = 6'd8;
    run_batch(4, -1, "R7");
  endtask

  task automatic test_flush();
    b_pc[0] = 32'h40; b_tag[0] = 6'd11;
    b_pc[1] = 32'h40; b_tag[1] = 6'd12;
    run_batch(2, 1, "R4");
    b_pc[0] = 32'h40; b_tag[0] = 6'd13;
    b_pc[1] = 32'h40; b_tag[1] = 6'd14;
    b_pc[2] = 32'h40; b_tag[2] = 6'd15;
    b_pc[3] = 32'h40; b_tag[3] = 6'd16;
    run_batch(4, 3, "R4");
  endtask

  task automatic test_mixed_training();
    for (int i = 0; i < 6; i++) do_update(32'h200 + 32'(i * 4), 1'b1);
    for (int i = 0; i < 4; i++) do_update(32'h40, 1'b0);
    do_update(32'h40, 1'b0);
    for (int i = 0; i < 8; i++) begin
      b_pc[i]  = 32'h200 + 32'(i * 4) + ((i % 2 == 0) ? 32'h0 : 32'h400);
      b_tag[i] = TAG_W'(20 + i);
    end
    run_batch(8, -1, "R5");
    for (int i = 0; i < 3; i++) do_update(32'h208, 1'b0);
    for (int i = 0; i < 8; i++) begin
      b_pc[i]  = 32'h200 + 32'((i % 4) * 4);
      b_tag[i] = TAG_W'(40 + i);
    end
    run_batch(8, -1, "R7");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    @(negedge clk);
    test_agree();
    test_train_disagree();
    test_back_to_back();
    test_flush();
    test_mixed_training();
    repeat (2) @(negedge clk);
    chk(cnt == CW'(exp_cnt), "R6", "final count", cnt, exp_cnt);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule